// File: doc/BRIEF.md
# Two-Wire Bus Register Slave

This block is a slave on a two-wire serial bus that gives a bus master access to a small bank of 8-bit registers. It oversamples the clock line and the data line with the system clock, recognises start, repeated start and stop conditions, and answers only to its own 7-bit device address, which is set by a parameter. It drives the data line only through an open-drain pull-down enable, for acknowledges and for read data. The register bank sits outside the block and is reached through a one-cycle write strobe and a combinational read port.

A register pointer selects the register being accessed. The first data byte of every write transaction loads this pointer. Each later byte in the transaction goes to the register it points at. On reads and on writes alike, the pointer moves to the next register after every acknowledged byte, and it wraps from the last register back to register 0. To read from a chosen register, the master writes only the pointer byte, sends a repeated start, and then sends the address with the read bit set. Before it presents each read byte, the slave holds the clock line low for a set number of system cycles. This gives the register port time to settle.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for a start.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: acknowledges the address.
- `ST_WR_BYTE` and `ST_WR_ACK`: receive a data byte and acknowledge it.
- `ST_RD_LOAD`: holds the clock low and fetches the register.
- `ST_RD_BYTE`: shifts the read data out.
- `ST_RD_ACK`: samples the master's acknowledge.
- `ST_IGNORE`: stays silent until the next start or stop.

The transitions are:
- A start detected in any state goes to `ST_ADDR`, and a stop detected in any state goes to `ST_IDLE`.
- From `ST_ADDR`, the clock fall after the eighth bit goes to `ST_ADDR_ACK` if the address matches, and to `ST_IGNORE` if it does not.
- From `ST_ADDR_ACK`, the clock fall goes to `ST_RD_LOAD` if the read/write bit is set, and to `ST_WR_BYTE` if it is clear.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits, and `ST_WR_ACK` returns to `ST_WR_BYTE` on the clock fall.
- `ST_RD_LOAD` goes to `ST_RD_BYTE` when the hold time has expired.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight falling edges of the clock.
- From `ST_RD_ACK`, the clock fall goes to `ST_RD_LOAD` if the master acknowledged, and to `ST_IGNORE` if it did not.

Top module: `twb_reg_slave`

## Requirements
- R1: While reset is active and after it is released, `sda_oe`, `scl_oe` and `reg_we` are low until a start condition is seen on the bus.
- R2: The first byte after a start is the address, sent MSB first, with bits 7..1 the device address and bit 0 the read/write flag (1 = read). When bits 7..1 equal `DEV_ADDR`, the slave pulls the data line low during the ninth clock.
- R3: When the address does not match, the slave never drives the data line, writes no register and leaves the pointer unchanged until the next start or stop.
- R4: The first data byte after a matching write address loads its low `PTR_W` bits into the register pointer, is acknowledged, and causes no register write.
- R5: Every later data byte of the write is acknowledged and written, with `reg_we` high for one cycle, to the register the pointer selects. The pointer then advances by one.
- R6: A read transaction returns the register at the pointer, MSB first. The pointer advances by one each time the master acknowledges a read byte.
- R7: A write of only the pointer byte, followed by a repeated start with the read bit set, returns data starting at that pointer.
- R8: After the master does not acknowledge a read byte, the slave releases the data line, drives nothing until the next start or stop, and leaves the pointer unchanged.
- R9: The pointer advances from register `NUM_REGS-1` to register 0, for both writes and reads.
- R10: When `STRETCH_CYC` is greater than 0, the slave holds the clock line low for `STRETCH_CYC` system cycles before it releases each read byte. It never holds the clock line low during write transfers.
- R11: A stop in the middle of a byte returns the slave to idle with the data line released, and writes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Clock line as seen on the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| scl_oe | output | 1 | Pulls the clock line low when high (stretching) |
| sda_oe | output | 1 | Pulls the data line low when high |
| reg_addr | output | PTR_W | Register pointer presented to the register bank |
| reg_wdata | output | 8 | Write data to the register bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Combinational read data of the register at `reg_addr` |

## Verification
The bench builds the slave with device address 0x2A, eight registers and a clock-stretch hold of 40 cycles. The master's low phase lasts only 20 cycles, so the stretch shows up as a measurable wait after the master releases the clock line. With only eight registers, both the write and read wrap from register 7 to register 0 are reached after a few bytes. Pointer persistence is exercised through a zero-data write followed by a repeated start, a master NACK, a foreign address and an aborted byte, each followed by a read that shows where the pointer was left.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_LOAD,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } twb_state_t;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/twb_line_sampler.sv
module twb_line_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_d;
    logic                   sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_sync[SYNC_STAGES-1];
            sda_d    <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sync[SYNC_STAGES-1];
    assign sda_s     = sda_sync[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twb_reg_pointer.sv
module twb_reg_pointer #(
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned PTR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R9: the pointer wraps from the last register to zero
    a_r9_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && ptr == LAST) |=> (ptr == '0));

endmodule

// File: rtl/twb_reg_slave.sv
module twb_reg_slave #(
    parameter logic [6:0]  DEV_ADDR    = 7'h2A,
    parameter int unsigned NUM_REGS    = 8,
    parameter int unsigned STRETCH_CYC = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned PTR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic [PTR_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    input  logic [7:0]       reg_rdata
);
    import twb_pkg::*;

    localparam int unsigned CNT_W = (STRETCH_CYC > 0) ? $clog2(STRETCH_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STRETCH_CYC);
    localparam logic [PTR_W-1:0] LAST    = PTR_W'(NUM_REGS - 1);

    twb_state_t        state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [3:0]        bitcnt;
    logic              rw_q;
    logic              first_q;
    logic              mst_ack_q;
    logic [CNT_W-1:0]  stretch_cnt;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic addr_hit, wr_done, ptr_load, ptr_inc, stretch_done;
    logic [PTR_W-1:0] ptr;

    twb_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twb_reg_pointer #(.NUM_REGS(NUM_REGS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (shreg[PTR_W-1:0]),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    assign addr_hit     = (shreg[7:1] == DEV_ADDR);
    assign wr_done      = (state == ST_WR_BYTE) && scl_fall && (bitcnt == 4'd8)
                          && !start_det && !stop_det;
    assign ptr_load     = wr_done && first_q;
    assign reg_we       = wr_done && !first_q;
    assign ptr_inc      = reg_we || ((state == ST_RD_ACK) && scl_rise && !sda_s);
    assign stretch_done = (state == ST_RD_LOAD) && (stretch_cnt >= CNT_END);
    assign reg_addr     = ptr;
    assign reg_wdata    = shreg;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     nxt = ST_IDLE;
            ST_ADDR:     if (scl_fall && bitcnt == 4'd8) nxt = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
            ST_ADDR_ACK: if (scl_fall) nxt = rw_q ? ST_RD_LOAD : ST_WR_BYTE;
            ST_WR_BYTE:  if (scl_fall && bitcnt == 4'd8) nxt = ST_WR_ACK;
            ST_WR_ACK:   if (scl_fall) nxt = ST_WR_BYTE;
            ST_RD_LOAD:  if (stretch_done) nxt = ST_RD_BYTE;
            ST_RD_BYTE:  if (scl_fall && bitcnt == 4'd7) nxt = ST_RD_ACK;
            ST_RD_ACK:   if (scl_fall) nxt = mst_ack_q ? ST_RD_LOAD : ST_IGNORE;
            ST_IGNORE:   nxt = ST_IGNORE;
            default:     nxt = ST_IDLE;
        endcase
        if (start_det)     nxt = ST_ADDR;
        else if (stop_det) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            bitcnt      <= '0;
            rw_q        <= 1'b0;
            first_q     <= 1'b0;
            mst_ack_q   <= 1'b0;
            stretch_cnt <= '0;
        end else begin
            if (nxt != state) begin
                bitcnt <= '0;
            end else if ((state == ST_ADDR || state == ST_WR_BYTE) && scl_rise) begin
                bitcnt <= bitcnt + 4'd1;
            end else if (state == ST_RD_BYTE && scl_fall) begin
                bitcnt <= bitcnt + 4'd1;
            end

            if ((state == ST_ADDR || state == ST_WR_BYTE) && scl_rise && bitcnt < 4'd8) begin
                shreg <= {shreg[6:0], sda_s};
            end else if (stretch_done) begin
                shreg <= reg_rdata;
            end else if (state == ST_RD_BYTE && scl_fall) begin
                shreg <= {shreg[6:0], 1'b0};
            end

            if (state == ST_ADDR && scl_fall && bitcnt == 4'd8) rw_q <= shreg[0];

            if (state == ST_ADDR_ACK && nxt == ST_WR_BYTE) first_q <= 1'b1;
            else if (ptr_load)                             first_q <= 1'b0;

            if (state == ST_RD_ACK && scl_rise) mst_ack_q <= ~sda_s;

            if (state == ST_RD_LOAD && !stretch_done) stretch_cnt <= stretch_cnt + 1'b1;
            else                                      stretch_cnt <= '0;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
            scl_oe <= 1'b0;
        end else begin
            sda_oe <= (state == ST_ADDR_ACK) || (state == ST_WR_ACK)
                      || ((state == ST_RD_BYTE) && !shreg[7]);
            scl_oe <= (state == ST_RD_LOAD);
        end
    end

    // R2: the data line is only pulled low while the clock line is low
    a_r2_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R3: silence while ignoring the bus
    a_r3_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE && $past(state) == ST_IGNORE) |-> !sda_oe);

    // R4: the pointer byte never reaches the register bank
    a_r4_no_write_on_ptr_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |-> !reg_we);

    // R5: each register write advances the pointer by one
    a_r5_ptr_advance_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == (($past(reg_addr) == LAST) ? '0 : $past(reg_addr) + 1'b1)));

    // R10: stretching only starts with the clock line already low
    a_r10_stretch_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !scl_s);

    // R10: no stretching during write transfers
    a_r10_no_stretch_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_BYTE || state == ST_WR_ACK) && $past(state) != ST_RD_LOAD |-> !scl_oe);

endmodule

// File: tb/twb_reg_slave_bench.sv
`timescale 1ns/1ps
module twb_reg_slave_bench;

    localparam logic [6:0] DEV  = 7'h2A;
    localparam int NREG = 8;
    localparam int PW   = 3;
    localparam int STR  = 40;
    localparam int H    = 20;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_oe, sda_oe, reg_we;
    logic [PW-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    wire scl = scl_m & ~scl_oe;
    wire sda = sda_m & ~sda_oe;

    logic [7:0] mem [NREG];
    logic [7:0] exp_mem [NREG];
    logic [15:0] wq [$];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    twb_reg_slave #(.DEV_ADDR(DEV), .NUM_REGS(NREG), .STRETCH_CYC(STR)) u_twb_reg_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    initial begin
        for (int i = 0; i < NREG; i++) begin
            mem[i] = 8'h10 + 8'(i);
            exp_mem[i] = 8'h10 + 8'(i);
        end
    end

    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: compares every register write against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && reg_we && !done) begin
            if (wq.size() == 0) begin
                chk(0, "R3", "unexpected register write", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [15:0] e;
                e = wq.pop_front();
                chk({8'(reg_addr), reg_wdata} == e, "R5", "register write addr/data",
                    {8'(reg_addr), reg_wdata}, e);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(output logic v, output int waited);
        scl_m = 1'b1;
        waited = 0;
        @(negedge clk);
        while (scl === 1'b0) begin
            waited++;
            @(negedge clk);
        end
        wait_clk(H/2);
        v = sda;
        wait_clk(H/2);
        scl_m = 1'b0;
        wait_clk(Q);
    endtask

    task automatic do_start();
        sda_m = 1'b1;
        wait_clk(Q);
        scl_m = 1'b1;
        wait_clk(H);
        sda_m = 1'b0;
        wait_clk(H);
        scl_m = 1'b0;
        wait_clk(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0;
        wait_clk(H-Q);
        scl_m = 1'b1;
        wait_clk(H);
        sda_m = 1'b1;
        wait_clk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output int stw);
        logic v;
        int w;
        stw = 0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            wait_clk(H-Q);
            pulse(v, w);
            if (w > stw) stw = w;
        end
        sda_m = 1'b1;
        wait_clk(H-Q);
        pulse(v, w);
        ack = !v;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b, output int stw);
        logic v;
        int w;
        sda_m = 1'b1;
        stw = 0;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(H-Q);
            pulse(v, w);
            b[i] = v;
            if (i == 7) stw = w;
        end
        sda_m = !give_ack;
        wait_clk(H-Q);
        pulse(v, w);
        sda_m = 1'b1;
    endtask

    task automatic addr_phase(input logic [6:0] a, input bit rd, input bit exp_ack, input string req);
        logic ack;
        int w;
        send_byte({a, rd}, ack, w);
        chk(ack == exp_ack, req, "address acknowledge", ack, exp_ack);
    endtask

    task automatic wr_data(input logic [7:0] d, input logic [PW-1:0] at, input string req);
        logic ack;
        int w;
        wq.push_back({8'(at), d});
        exp_mem[at] = d;
        send_byte(d, ack, w);
        chk(ack == 1'b1, req, "data acknowledge", ack, 1);
        chk(w == 0, "R10", "no stretch during write", w, 0);
    endtask

    task automatic rd_data(input logic [PW-1:0] at, input bit give_ack, input string req);
        logic [7:0] b;
        int w;
        recv_byte(give_ack, b, w);
        chk(b == exp_mem[at], req, "read data", b, exp_mem[at]);
        chk(w >= 10, "R10", "stretch before read byte", w, 10);
    endtask

    task automatic set_ptr(input logic [7:0] p);
        logic ack;
        int w;
        send_byte(p, ack, w);
        chk(ack == 1'b1, "R4", "pointer byte acknowledge", ack, 1);
    endtask

    initial begin
        // R1: reset state
        wait_clk(3);
        chk(sda_oe == 0 && scl_oe == 0 && reg_we == 0, "R1", "outputs in reset", {sda_oe, scl_oe, reg_we}, 0);
        rst_n = 1'b1;
        wait_clk(10);
        chk(sda_oe == 0 && scl_oe == 0 && reg_we == 0, "R1", "outputs after reset", {sda_oe, scl_oe, reg_we}, 0);

        // R2 R4 R5: pointer 3, two data bytes
        do_start();
        addr_phase(DEV, 0, 1, "R2");
        set_ptr(8'h03);
        wr_data(8'hA1, 3'd3, "R5");
        wr_data(8'hB2, 3'd4, "R5");
        do_stop();

        // R9: write wraps from 7 to 0
        do_start();
        addr_phase(DEV, 0, 1, "R2");
        set_ptr(8'h07);
        wr_data(8'hC3, 3'd7, "R9");
        wr_data(8'hD4, 3'd0, "R9");
        do_stop();

        // R7 R6 R8: zero-data write then repeated start read
        do_start();
        addr_phase(DEV, 0, 1, "R2");
        set_ptr(8'h03);
        do_start();
        addr_phase(DEV, 1, 1, "R7");
        rd_data(3'd3, 1, "R7");
        rd_data(3'd4, 0, "R6");
        begin
            logic v;
            int w;
            sda_m = 1'b1;
            wait_clk(H-Q);
            pulse(v, w);
            chk(v == 1'b1 && sda_oe == 0, "R8", "data line released after NACK", v, 1);
        end
        do_stop();

        // R8: pointer unchanged by the NACKed byte (still 4)
        do_start();
        addr_phase(DEV, 1, 1, "R2");
        rd_data(3'd4, 1, "R8");
        rd_data(3'd5, 0, "R6");
        do_stop();

        // R3: foreign address is ignored
        do_start();
        addr_phase(7'h55, 0, 0, "R3");
        begin
            logic ack;
            int w;
            send_byte(8'h00, ack, w);
            chk(ack == 0, "R3", "no acknowledge after mismatch", ack, 0);
            send_byte(8'hEE, ack, w);
            chk(ack == 0, "R3", "no acknowledge after mismatch", ack, 0);
        end
        do_stop();
        do_start();
        addr_phase(DEV, 1, 1, "R2");
        rd_data(3'd5, 0, "R3");
        do_stop();

        // R11: stop in the middle of a data byte
        do_start();
        addr_phase(DEV, 0, 1, "R2");
        set_ptr(8'h00);
        begin
            logic v;
            int w;
            for (int i = 0; i < 4; i++) begin
                sda_m = i[0];
                wait_clk(H-Q);
                pulse(v, w);
            end
        end
        do_stop();
        chk(sda_oe == 0 && scl_oe == 0, "R11", "released after mid-byte stop", {sda_oe, scl_oe}, 0);
        do_start();
        addr_phase(DEV, 1, 1, "R11");
        rd_data(3'd0, 0, "R11");
        do_stop();

        // R9: read wraps from 7 to 0
        do_start();
        addr_phase(DEV, 0, 1, "R2");
        set_ptr(8'h07);
        do_start();
        addr_phase(DEV, 1, 1, "R7");
        rd_data(3'd7, 1, "R9");
        rd_data(3'd0, 1, "R9");
        rd_data(3'd1, 0, "R9");
        do_stop();

        wait_clk(10);
        chk(wq.size() == 0, "R5", "all expected writes seen", wq.size(), 0);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule